// File: doc/BRIEF.md
# TDM Chain Slot Controller

This block owns a group of six 16-bit time slots on a shared time-division serial bus. Several such devices hang on the same serial clock, data and frame-sync lines and take turns by passing a token: a device waits for its token input, runs its window of slots, and raises its token output during the window's final bit. The next device in the chain sees that pulse and starts its own window on the following bit period. Outgoing slot words come in on a parallel port and are shifted out one bit at a time. Incoming bits are assembled into six parallel words, and a one-cycle strobe marks them ready.

The block runs on a fast system clock and treats the serial clock as a sampled input. It detects the serial clock's edges inside the block. Serial data is launched after a rising edge and captured at a falling edge. One device on the bus acts as master. It ignores the token input and opens its window from frame sync, so it takes the first slots of each frame. A device that is deselected or powered down drops out of the chain: its token output simply mirrors its token input, and its data driver is released.

Top module: `tdm_chain_port`

## Requirements
- R1: With the block enabled (`cs_i` high, `pdn_i` low), idle, and not in master mode, a high `tsi_i` seen at a serial-clock rising edge opens a window. `sdo_oe_o` goes high right after that edge and stays high for exactly 96 bit periods, then drops.
- R2: Within a window, slot 0 is sent first and each slot word is sent MSB first. Bit period n of the window carries `tx_words_i[n/16][15 - n%16]`, and `sdo_o` changes only just after a serial-clock rising edge.
- R3: While the block is enabled, `tso_o` is high for exactly one bit period: the 96th bit period of a window. It is low at all other times.
- R4: Once a window is open, a start condition (`tsi_i` or `fsync_i`) arriving before the final bit has no effect. The bit sequence and the `tso_o` timing stay as they were.
- R5: With `master_i` high, a high `fsync_i` at a rising edge opens the window and `tsi_i` is ignored. With `master_i` low, `fsync_i` is ignored.
- R6: With `cs_i` low or `pdn_i` high, `tso_o` equals `tsi_i` at all times, `sdo_oe_o` is low, and no window opens.
- R7: Deselecting or powering down the block during a window ends the window at once. That window then produces no `tso_o` pulse and no `rx_valid_o` strobe.
- R8: During a window, `sdi_i` is sampled at each falling edge and placed at `rx_words_o[n/16][15 - n%16]` for bit period n. At the falling edge of the final bit, all six words appear together on `rx_words_o` and `rx_valid_o` is high for one system-clock cycle.
- R9: After synchronous reset with the block enabled, `sdo_oe_o`, `tso_o` and `rx_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than the serial clock |
| rst_i | input | 1 | Synchronous reset, active high |
| sclk_i | input | 1 | Serial bit clock |
| fsync_i | input | 1 | Frame sync; starts the window in master mode |
| sdi_i | input | 1 | Serial receive data |
| sdo_o | output | 1 | Serial transmit data |
| sdo_oe_o | output | 1 | Output enable for the transmit driver |
| tsi_i | input | 1 | Token input from the previous device |
| tso_o | output | 1 | Token output to the next device |
| cs_i | input | 1 | Chip select, active high |
| pdn_i | input | 1 | Power-down, active high |
| master_i | input | 1 | Bus-master mode select |
| tx_words_i | input | 6x16 | Transmit words, one per slot |
| rx_words_o | output | 6x16 | Received words, one per slot |
| rx_valid_o | output | 1 | One-cycle strobe when all received words are ready |

## Verification
The bench builds the block with its default geometry: six slots of sixteen bits, so each window is 96 bit periods long. At four system clocks per bit, a full window plus idle margin fits in a few hundred cycles. That leaves room for many random frames in both slave and master mode, with random slot words and random receive data. These default sizes also bring the final-bit boundary, a token that arrives in the middle of a window, an abort at bit 40, and full-time bypass all within a short run.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

    typedef enum logic {
        SLOT_IDLE = 1'b0,
        SLOT_BUSY = 1'b1
    } slot_mode_e;

endpackage

// File: rtl/tdm_sclk_edge.sv
module tdm_sclk_edge (
    input  logic clk_i,
    input  logic rst_i,
    input  logic sclk_i,
    output logic rise_o,
    output logic fall_o
);
    logic sclk_d, sclk_q;

    always_comb begin
        sclk_d = sclk_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) sclk_q <= 1'b0;
        else       sclk_q <= sclk_d;
    end

    assign rise_o = sclk_i & ~sclk_q;
    assign fall_o = ~sclk_i & sclk_q;
endmodule

// File: rtl/tdm_slot_seq.sv
module tdm_slot_seq
    import tdm_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int SLOTS = 6
) (
    input  logic                        clk_i,
    input  logic                        rst_i,
    input  logic                        en_i,
    input  logic                        rise_i,
    input  logic                        start_i,
    input  logic [SLOTS-1:0][WIDTH-1:0] tx_words_i,
    output logic                        busy_o,
    output logic [((SLOTS>1)?$clog2(SLOTS):1)-1:0] slot_o,
    output logic [$clog2(WIDTH)-1:0]    bit_o,
    output logic                        sdo_o,
    output logic                        tso_o
);
    localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int BW = $clog2(WIDTH);
    localparam logic [SW-1:0] LAST_SLOT = SW'(SLOTS - 1);
    localparam logic [BW-1:0] LAST_BIT  = BW'(WIDTH - 1);

    typedef struct packed {
        slot_mode_e    mode;
        logic [SW-1:0] slot;
        logic [BW-1:0] bitn;
        logic          sdo;
        logic          tso;
    } seq_t;

    seq_t s_d, s_q;
    logic          final_bit;
    logic          idle;
    logic [SW-1:0] nxt_slot;
    logic [BW-1:0] nxt_bit;

    always_comb begin
        s_d       = s_q;
        idle      = (s_q.mode == SLOT_IDLE);
        final_bit = !idle && (s_q.slot == LAST_SLOT) && (s_q.bitn == LAST_BIT);
        if (s_q.bitn == LAST_BIT) begin
            nxt_bit  = '0;
            nxt_slot = s_q.slot + 1'b1;
        end else begin
            nxt_bit  = s_q.bitn + 1'b1;
            nxt_slot = s_q.slot;
        end

        if (!en_i) begin
            s_d.mode = SLOT_IDLE;
            s_d.sdo  = 1'b0;
            s_d.tso  = 1'b0;
        end else if (rise_i) begin
            if ((idle || final_bit) && start_i) begin
                s_d.mode = SLOT_BUSY;
                s_d.slot = '0;
                s_d.bitn = '0;
                s_d.sdo  = tx_words_i[0][WIDTH-1];
                s_d.tso  = 1'b0;
            end else if (idle || final_bit) begin
                s_d.mode = SLOT_IDLE;
                s_d.sdo  = 1'b0;
                s_d.tso  = 1'b0;
            end else begin
                s_d.slot = nxt_slot;
                s_d.bitn = nxt_bit;
                s_d.sdo  = tx_words_i[nxt_slot][LAST_BIT - nxt_bit];
                s_d.tso  = (nxt_slot == LAST_SLOT) && (nxt_bit == LAST_BIT);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) s_q <= '{mode: SLOT_IDLE, slot: '0, bitn: '0, sdo: 1'b0, tso: 1'b0};
        else       s_q <= s_d;
    end

    assign busy_o = (s_q.mode == SLOT_BUSY);
    assign slot_o = s_q.slot;
    assign bit_o  = s_q.bitn;
    assign sdo_o  = s_q.sdo;
    assign tso_o  = s_q.tso;
endmodule

// File: rtl/tdm_rx_capture.sv
module tdm_rx_capture #(
    parameter int WIDTH = 16,
    parameter int SLOTS = 6
) (
    input  logic                        clk_i,
    input  logic                        rst_i,
    input  logic                        en_i,
    input  logic                        fall_i,
    input  logic                        busy_i,
    input  logic [((SLOTS>1)?$clog2(SLOTS):1)-1:0] slot_i,
    input  logic [$clog2(WIDTH)-1:0]    bit_i,
    input  logic                        sdi_i,
    output logic [SLOTS-1:0][WIDTH-1:0] words_o,
    output logic                        valid_o
);
    localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int BW = $clog2(WIDTH);
    localparam logic [SW-1:0] LAST_SLOT = SW'(SLOTS - 1);
    localparam logic [BW-1:0] LAST_BIT  = BW'(WIDTH - 1);

    typedef struct packed {
        logic [SLOTS-1:0][WIDTH-1:0] work;
        logic [SLOTS-1:0][WIDTH-1:0] words;
        logic                        valid;
    } rx_t;

    rx_t r_d, r_q;
    logic [SLOTS-1:0][WIDTH-1:0] fill;

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        fill      = r_q.work;
        if (en_i && fall_i && busy_i) begin
            fill[slot_i][LAST_BIT - bit_i] = sdi_i;
            r_d.work = fill;
            if ((slot_i == LAST_SLOT) && (bit_i == LAST_BIT)) begin
                r_d.words = fill;
                r_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) r_q <= '0;
        else       r_q <= r_d;
    end

    assign words_o = r_q.words;
    assign valid_o = r_q.valid;
endmodule

// File: rtl/tdm_chain_port.sv
module tdm_chain_port #(
    parameter int WIDTH = 16,
    parameter int SLOTS = 6
) (
    input  logic                        clk_i,
    input  logic                        rst_i,
    input  logic                        sclk_i,
    input  logic                        fsync_i,
    input  logic                        sdi_i,
    output logic                        sdo_o,
    output logic                        sdo_oe_o,
    input  logic                        tsi_i,
    output logic                        tso_o,
    input  logic                        cs_i,
    input  logic                        pdn_i,
    input  logic                        master_i,
    input  logic [SLOTS-1:0][WIDTH-1:0] tx_words_i,
    output logic [SLOTS-1:0][WIDTH-1:0] rx_words_o,
    output logic                        rx_valid_o
);
    localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int BW = $clog2(WIDTH);

    logic          rise_w, fall_w;
    logic          en_w, start_w, busy_w, tso_w, sdo_w;
    logic [SW-1:0] slot_w;
    logic [BW-1:0] bit_w;

    assign en_w    = cs_i & ~pdn_i;
    assign start_w = master_i ? fsync_i : tsi_i;

    tdm_sclk_edge u_edge (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .sclk_i (sclk_i),
        .rise_o (rise_w),
        .fall_o (fall_w)
    );

    tdm_slot_seq #(.WIDTH(WIDTH), .SLOTS(SLOTS)) u_seq (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .en_i       (en_w),
        .rise_i     (rise_w),
        .start_i    (start_w),
        .tx_words_i (tx_words_i),
        .busy_o     (busy_w),
        .slot_o     (slot_w),
        .bit_o      (bit_w),
        .sdo_o      (sdo_w),
        .tso_o      (tso_w)
    );

    tdm_rx_capture #(.WIDTH(WIDTH), .SLOTS(SLOTS)) u_rx (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .en_i    (en_w),
        .fall_i  (fall_w),
        .busy_i  (busy_w),
        .slot_i  (slot_w),
        .bit_i   (bit_w),
        .sdi_i   (sdi_i),
        .words_o (rx_words_o),
        .valid_o (rx_valid_o)
    );

    assign sdo_o    = sdo_w;
    assign sdo_oe_o = en_w & busy_w;
    assign tso_o    = en_w ? tso_w : tsi_i;
endmodule

// File: rtl/tdm_chain_port_chk.sv
module tdm_chain_port_chk (
    input logic clk_i,
    input logic rst_i,
    input logic cs_i,
    input logic pdn_i,
    input logic tso_o,
    input logic sdo_o,
    input logic sdo_oe_o,
    input logic rx_valid_o,
    input logic rise_i
);
    // R3: an enabled token pulse only occurs while the window drives data
    assert_tso_in_window_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (tso_o && cs_i && !pdn_i) |-> sdo_oe_o);

    // R8: the receive strobe lasts one system-clock cycle
    assert_rx_strobe_single_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        rx_valid_o |=> !rx_valid_o);

    // R7: a disabled block never finishes a receive window
    assert_no_strobe_when_off_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (!cs_i || pdn_i) |=> !rx_valid_o);

    // R2: transmit data only moves just after a serial rising edge
    assert_sdo_moves_on_rise_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (sdo_oe_o && $past(sdo_oe_o) && !$past(rise_i)) |-> $stable(sdo_o));
endmodule

bind tdm_chain_port tdm_chain_port_chk u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .cs_i       (cs_i),
    .pdn_i      (pdn_i),
    .tso_o      (tso_o),
    .sdo_o      (sdo_o),
    .sdo_oe_o   (sdo_oe_o),
    .rx_valid_o (rx_valid_o),
    .rise_i     (rise_w)
);

// File: tb/tdm_chain_port_test.sv
module tdm_chain_port_test;
    localparam int W = 16;
    localparam int S = 6;
    localparam int NBITS = W * S;

    logic clk = 1'b0;
    logic rst, sclk, fsync, sdi, tsi, cs, pdn, master;
    logic sdo, sdo_oe, tso, rx_valid;
    logic [S-1:0][W-1:0] tx_words, rx_words;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tdm_chain_port #(.WIDTH(W), .SLOTS(S)) uut (
        .clk_i(clk), .rst_i(rst), .sclk_i(sclk), .fsync_i(fsync), .sdi_i(sdi),
        .sdo_o(sdo), .sdo_oe_o(sdo_oe), .tsi_i(tsi), .tso_o(tso), .cs_i(cs),
        .pdn_i(pdn), .master_i(master), .tx_words_i(tx_words),
        .rx_words_o(rx_words), .rx_valid_o(rx_valid)
    );

    task automatic check(input bit ok, input string tag, input logic [NBITS-1:0] act,
                         input logic [NBITS-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic tx_bit(input logic [S-1:0][W-1:0] words, input int n);
        return words[n / W][W - 1 - (n % W)];
    endfunction

    task automatic do_reset(input bit m);
        rst = 1'b1; sclk = 1'b0; fsync = 1'b0; sdi = 1'b0; tsi = 1'b0;
        cs = 1'b1; pdn = 1'b0; master = m;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // s: call after which the start condition is on the wire
    // glitch: extra start condition mid-window (-1 none); abort_c: first call with cs low
    task automatic run_case(input bit m, input int s, input int glitch, input int abort_c,
                            input bit desel, input bit pd, input string tag);
        logic [S-1:0][W-1:0] exp_rx;
        bit alive;
        do_reset(m);
        for (int k = 0; k < S; k++) tx_words[k] = W'($urandom);
        exp_rx = '0;
        alive = 1'b0;
        cs  = !desel;
        pdn = pd;
        for (int c = 0; c < s + NBITS + 4; c++) begin
            bit en_c;
            int idx;
            logic tsi_cur;
            logic sdi_v;
            en_c    = cs && !pdn;
            tsi_cur = tsi;
            idx     = c - (s + 1);
            if (c == s + 1 && en_c) alive = 1'b1;
            if (!en_c || idx >= NBITS) alive = 1'b0;
            sdi_v = 1'($urandom);
            if (alive) exp_rx[idx / W][W - 1 - (idx % W)] = sdi_v;

            @(negedge clk); sclk = 1'b1; sdi = sdi_v;
            @(negedge clk);
            // R1 / R6 / R7: driver enable
            check(sdo_oe == alive, en_c ? {tag, " R1 sdo_oe"} : {tag, " R6 sdo_oe"},
                  NBITS'(sdo_oe), NBITS'(alive));
            if (alive) begin
                // R2: bit order
                check(sdo == tx_bit(tx_words, idx), {tag, " R2 sdo"},
                      NBITS'(sdo), NBITS'(tx_bit(tx_words, idx)));
            end
            if (en_c) begin
                // R3: token pulse on final bit
                check(tso == (alive && idx == NBITS - 1), {tag, " R3 tso"},
                      NBITS'(tso), NBITS'(alive && idx == NBITS - 1));
            end else begin
                // R6: token bypass
                check(tso == tsi_cur, {tag, " R6 tso bypass"}, NBITS'(tso), NBITS'(tsi_cur));
            end
            @(negedge clk); sclk = 1'b0;
            @(negedge clk);
            // R8: receive strobe and data
            check(rx_valid == (alive && idx == NBITS - 1), {tag, " R8 rx_valid"},
                  NBITS'(rx_valid), NBITS'(alive && idx == NBITS - 1));
            if (alive && idx == NBITS - 1)
                check(rx_words == exp_rx, {tag, " R8 rx_words"}, rx_words, exp_rx);

            if (m || desel || pd) tsi = 1'($urandom);
            else                  tsi = (c == s) || (c == glitch);
            fsync = m ? (c == s) : 1'($urandom);
            cs    = !(desel || (abort_c >= 0 && c + 1 >= abort_c));
        end
    endtask

    initial begin
        void'($urandom(32'd2468));
        do_reset(1'b0);
        // R9: reset state
        check(sdo_oe == 1'b0, "R9 sdo_oe", NBITS'(sdo_oe), '0);
        check(tso == 1'b0, "R9 tso", NBITS'(tso), '0);
        check(rx_valid == 1'b0, "R9 rx_valid", NBITS'(rx_valid), '0);

        run_case(1'b0, 2, -1, -1, 1'b0, 1'b0, "R1 slave");
        run_case(1'b0, 5, 35, -1, 1'b0, 1'b0, "R4 glitch");
        run_case(1'b1, 1, -1, -1, 1'b0, 1'b0, "R5 master");
        run_case(1'b0, 3, -1, -1, 1'b1, 1'b0, "R6 deselected");
        run_case(1'b0, 3, -1, -1, 1'b0, 1'b1, "R6 powerdown");
        run_case(1'b0, 4, -1, 4 + 1 + 40, 1'b0, 1'b0, "R7 abort");
        for (int i = 0; i < 6; i++) begin
            bit m;
            int s;
            m = 1'($urandom);
            s = 1 + int'($urandom % 8);
            run_case(m, s, m ? -1 : s + 10 + int'($urandom % 60), -1, 1'b0, 1'b0,
                     m ? "R5 random" : "R4 random");
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule